// File: doc/BRIEF.md
# Operand-Latched 16-bit ALU with Flag-Only Compare

This block is the arithmetic and logic unit of a small 16-bit processor datapath. It keeps each of its two operands in its own clocked latch. The first operand comes only from the general-purpose register read port. The second comes only from the shared data bus, so it can be a memory word or a register value that was placed on the bus. A third latch holds the result that goes back to the register file. Each of the three latches has its own enable.

A 4-bit function code selects one of eleven operations. Six are arithmetic and logic operations on the two latched operands. Four are shifts or rotates of the first operand. The last is a compare, which sets the four status flags (zero, carry, negative, overflow) for a later branch decision and never loads the result latch. The adder is made of 4-bit slices joined by a group carry-lookahead stage. The control sequencer drives the operand enables in one cycle. It then drives the operation strobe and the result enable in a later cycle.

Top module: `alu_latched`

## Requirements
- R1: On a rising clock edge with `ld_a` high, operand A takes `reg_rd`. With `ld_a` low, operand A keeps its value.
- R2: On a rising clock edge with `ld_b` high, operand B takes `bus_in`. With `ld_b` low, operand B keeps its value.
- R3: On a rising clock edge with `res_en` high and a valid non-compare code on `func`, `res_out` takes the operation result computed from the latched operands. Otherwise `res_out` holds its value.
- R4: Code 10 (compare) sets the flags exactly as subtract (code 1) would. It leaves `res_out` unchanged even when `res_en` is high.
- R5: Code 0 selects ADD and code 1 selects SUB (A-B). Codes 2, 3, 4 and 5 select AND, OR, XOR and NOT, where NOT is the inverse of A.
- R6: ADD sets C to the unsigned carry out of bit 15. It sets V when A and B have the same sign and the result sign differs from it.
- R7: SUB and compare set C to 1 on a borrow (A < B unsigned). They set V when A and B have different signs and the result sign differs from the sign of A.
- R8: Codes 6, 7, 8 and 9 select shift left, shift right, rotate left and rotate right of A. Shifts fill the vacated bit with 0. Rotates fill it with the bit shifted out. C takes the bit shifted out and V is cleared.
- R9: Z is set when the 16-bit result is zero, and N equals result bit 15. The logic operations (codes 2 to 5) clear C and V.
- R10: Flags change only on a rising edge with `op_go` high. Codes 11 to 15 change neither the flags nor `res_out`.
- R11: A synchronous active-high `rst` clears both operands, `res_out` and all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 16 | Register file read data, source of operand A |
| ld_a | input | 1 | Capture enable for operand A |
| bus_in | input | 16 | Data bus value, source of operand B |
| ld_b | input | 1 | Capture enable for operand B |
| func | input | 4 | Operation code |
| op_go | input | 1 | Operation strobe; updates the flags |
| res_en | input | 1 | Result latch enable |
| res_out | output | 16 | Latched result toward the register file |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / borrow / shifted-out bit |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
Directed operands test the carry and sign boundaries. 0xFFFF+1 tells a carry with a zero result apart from a plain wrap. 0x7FFF+1 tells signed overflow apart from carry. 0-1 shows a borrow, and an equal compare shows the zero flag. 0x8001 separates each shift from its rotate, because only the rotate brings the end bit back in. Further directed steps load one operand while the other is held and leave the strobes low, to show that each latch keeps its value. A seeded random mix of operands, codes and strobes covers the invalid codes and the case of compare with the result enable high.

// File: rtl/alu_pkg.sv
package alu_pkg;

    parameter int unsigned DATA_W  = 16;
    parameter int unsigned SLICE_W = 4;

    typedef enum logic [3:0] {
        FN_ADD = 4'd0,
        FN_SUB = 4'd1,
        FN_AND = 4'd2,
        FN_OR  = 4'd3,
        FN_XOR = 4'd4,
        FN_NOT = 4'd5,
        FN_SHL = 4'd6,
        FN_SHR = 4'd7,
        FN_ROL = 4'd8,
        FN_ROR = 4'd9,
        FN_CMP = 4'd10
    } fn_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
    } flags_t;

    function automatic logic fn_valid(input logic [3:0] f);
        return f <= FN_CMP;
    endfunction

    function automatic logic fn_is_logic(input logic [3:0] f);
        return (f == FN_AND) || (f == FN_OR) || (f == FN_XOR) || (f == FN_NOT);
    endfunction

    function automatic logic fn_is_shift(input logic [3:0] f);
        return (f == FN_SHL) || (f == FN_SHR) || (f == FN_ROL) || (f == FN_ROR);
    endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         gen,
    output logic         prop
);
    logic [W:0] raw;

    always_comb begin
        raw  = {1'b0, a} + {1'b0, b};
        sum  = raw[W-1:0] + {{(W-1){1'b0}}, cin};
        gen  = raw[W];
        prop = &(a ^ b);
    end
endmodule

// File: rtl/alu_lookahead.sv
module alu_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] gen,
    input  logic [N-1:0] prop,
    input  logic         cin,
    output logic [N:0]   carry
);
    logic acc;

    always_comb begin
        acc   = 1'b0;
        carry = '0;
        for (int i = 0; i <= N; i++) begin
            acc = cin;
            for (int j = 0; j < i; j++) begin
                acc = gen[j] | (prop[j] & acc);
            end
            carry[i] = acc;
        end
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic         left,
    input  logic         rot,
    output logic [W-1:0] y,
    output logic         out_bit
);
    always_comb begin
        if (left) begin
            out_bit = a[W-1];
            y       = {a[W-2:0], rot ? a[W-1] : 1'b0};
        end else begin
            out_bit = a[0];
            y       = {rot ? a[0] : 1'b0, a[W-1:1]};
        end
    end
endmodule

// File: rtl/alu_latched.sv
module alu_latched
    import alu_pkg::*;
#(
    parameter int unsigned DW = alu_pkg::DATA_W,
    parameter int unsigned SW = alu_pkg::SLICE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] reg_rd,
    input  logic          ld_a,
    input  logic [DW-1:0] bus_in,
    input  logic          ld_b,
    input  logic [3:0]    func,
    input  logic          op_go,
    input  logic          res_en,
    output logic [DW-1:0] res_out,
    output logic          flag_z,
    output logic          flag_c,
    output logic          flag_n,
    output logic          flag_v
);
    localparam int unsigned NS = DW / SW;

    logic [DW-1:0] opa_q, opb_q, res_q;
    flags_t        flg_q;

    // operand latches
    always_ff @(posedge clk) begin
        if (rst) begin
            opa_q <= '0;
            opb_q <= '0;
        end else begin
            if (ld_a) opa_q <= reg_rd;
            if (ld_b) opb_q <= bus_in;
        end
    end

    p_a_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !ld_a |=> $stable(opa_q));
    p_b_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !ld_b |=> $stable(opb_q));

    // sliced adder with lookahead
    logic          sub_mode;
    logic [DW-1:0] b_eff, sum;
    logic [NS-1:0] g_s, p_s;
    logic [NS:0]   c_s;

    assign sub_mode = (func == FN_SUB) || (func == FN_CMP);
    assign b_eff    = sub_mode ? ~opb_q : opb_q;

    for (genvar s = 0; s < NS; s++) begin : g_slice
        alu_slice #(.W(SW)) u_slice (
            .a    (opa_q[s*SW +: SW]),
            .b    (b_eff[s*SW +: SW]),
            .cin  (c_s[s]),
            .sum  (sum[s*SW +: SW]),
            .gen  (g_s[s]),
            .prop (p_s[s])
        );
    end

    alu_lookahead #(.N(NS)) u_cla (
        .gen   (g_s),
        .prop  (p_s),
        .cin   (sub_mode),
        .carry (c_s)
    );

    // shift / rotate of A
    logic [DW-1:0] shy;
    logic          sh_out;

    alu_shifter #(.W(DW)) u_shift (
        .a       (opa_q),
        .left    ((func == FN_SHL) || (func == FN_ROL)),
        .rot     ((func == FN_ROL) || (func == FN_ROR)),
        .y       (shy),
        .out_bit (sh_out)
    );

    // function select
    logic [DW-1:0] nxt_res;
    flags_t        nxt_flg;

    always_comb begin
        nxt_res = '0;
        nxt_flg = '0;
        case (func)
            FN_ADD: begin
                nxt_res   = sum;
                nxt_flg.c = c_s[NS];
                nxt_flg.v = (opa_q[DW-1] == opb_q[DW-1]) && (sum[DW-1] != opa_q[DW-1]);
            end
            FN_SUB, FN_CMP: begin
                nxt_res   = sum;
                nxt_flg.c = ~c_s[NS];
                nxt_flg.v = (opa_q[DW-1] != opb_q[DW-1]) && (sum[DW-1] != opa_q[DW-1]);
            end
            FN_AND: nxt_res = opa_q & opb_q;
            FN_OR:  nxt_res = opa_q | opb_q;
            FN_XOR: nxt_res = opa_q ^ opb_q;
            FN_NOT: nxt_res = ~opa_q;
            FN_SHL, FN_SHR, FN_ROL, FN_ROR: begin
                nxt_res   = shy;
                nxt_flg.c = sh_out;
            end
            default: nxt_res = '0;
        endcase
        nxt_flg.z = (nxt_res == '0);
        nxt_flg.n = nxt_res[DW-1];
    end

    // result latch and flag register
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            flg_q <= '0;
        end else begin
            if (res_en && fn_valid(func) && (func != FN_CMP)) res_q <= nxt_res;
            if (op_go && fn_valid(func)) flg_q <= nxt_flg;
        end
    end

    p_cmp_keeps_result_r4: assert property (@(posedge clk) disable iff (rst)
        (func == FN_CMP) |=> $stable(res_q));
    p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!op_go || !fn_valid(func)) |=> $stable(flg_q));
    p_logic_clears_cv_r9: assert property (@(posedge clk) disable iff (rst)
        (op_go && fn_is_logic(func)) |=> (!flg_q.c && !flg_q.v));
    p_shift_no_v_r8: assert property (@(posedge clk) disable iff (rst)
        (op_go && fn_is_shift(func)) |=> !flg_q.v);
    p_result_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !res_en |=> $stable(res_q));

    assign res_out = res_q;
    assign flag_z  = flg_q.z;
    assign flag_c  = flg_q.c;
    assign flag_n  = flg_q.n;
    assign flag_v  = flg_q.v;

endmodule

// File: tb/tb_alu_latched.sv
module tb_alu_latched;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] reg_rd, bus_in;
    logic        ld_a, ld_b, op_go, res_en;
    logic [3:0]  func;
    logic [15:0] res_out;
    logic        flag_z, flag_c, flag_n, flag_v;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] e_a = '0, e_b = '0, e_res = '0;
    logic [3:0]  e_flg = '0;   // {z,c,n,v}

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_latched dut (
        .clk(clk), .rst(rst), .reg_rd(reg_rd), .ld_a(ld_a), .bus_in(bus_in),
        .ld_b(ld_b), .func(func), .op_go(op_go), .res_en(res_en),
        .res_out(res_out), .flag_z(flag_z), .flag_c(flag_c),
        .flag_n(flag_n), .flag_v(flag_v)
    );

    typedef struct {
        logic [15:0] r;
        logic [3:0]  f;
        bit          ok;
    } exp_t;

    function automatic exp_t model(logic [15:0] a, logic [15:0] b, logic [3:0] f);
        exp_t e;
        logic [16:0] w;
        logic c = 1'b0, v = 1'b0;
        e.ok = (f <= 4'd10);
        e.r  = '0;
        case (f)
            4'd0: begin
                w = {1'b0, a} + {1'b0, b}; e.r = w[15:0]; c = w[16];
                v = (a[15] == b[15]) && (e.r[15] != a[15]);
            end
            4'd1, 4'd10: begin
                e.r = a - b; c = (a < b);
                v = (a[15] != b[15]) && (e.r[15] != a[15]);
            end
            4'd2: e.r = a & b;
            4'd3: e.r = a | b;
            4'd4: e.r = a ^ b;
            4'd5: e.r = ~a;
            4'd6: begin e.r = {a[14:0], 1'b0};  c = a[15]; end
            4'd7: begin e.r = {1'b0, a[15:1]};  c = a[0];  end
            4'd8: begin e.r = {a[14:0], a[15]}; c = a[15]; end
            4'd9: begin e.r = {a[0], a[15:1]};  c = a[0];  end
            default: e.r = '0;
        endcase
        e.f = {(e.r == 16'h0), c, e.r[15], v};
        return e;
    endfunction

    function automatic string tag(logic [3:0] f);
        case (f)
            4'd0: return "R6";
            4'd1: return "R7";
            4'd2, 4'd3, 4'd4, 4'd5: return "R5/R9";
            4'd6, 4'd7, 4'd8, 4'd9: return "R8";
            4'd10: return "R4";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string t, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, got, exp);
        end
    endtask

    task automatic op(logic [15:0] a, logic [15:0] b, bit la, bit lb,
                      logic [3:0] f, bit go, bit wr, string t);
        exp_t m;
        @(negedge clk);
        reg_rd = a; bus_in = b; ld_a = la; ld_b = lb;
        op_go = 1'b0; res_en = 1'b0;
        @(negedge clk);
        ld_a = 1'b0; ld_b = 1'b0; func = f; op_go = go; res_en = wr;
        @(negedge clk);
        op_go = 1'b0; res_en = 1'b0;
        if (la) e_a = a;
        if (lb) e_b = b;
        m = model(e_a, e_b, f);
        if (go && m.ok) e_flg = m.f;
        if (wr && m.ok && f != 4'd10) e_res = m.r;
        chk({t, " result"}, res_out, e_res);
        chk({t, " flags"}, {12'h0, flag_z, flag_c, flag_n, flag_v}, {12'h0, e_flg});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        rst = 1'b1; reg_rd = '0; bus_in = '0; ld_a = 0; ld_b = 0;
        func = '0; op_go = 0; res_en = 0;
        @(negedge clk); @(negedge clk);
        // R11: reset state
        chk("R11 reset", {11'h0, res_out, flag_z, flag_c, flag_n, flag_v} , '0);
        rst = 1'b0;

        // R6 carry with zero result, signed overflow
        op(16'hFFFF, 16'h0001, 1, 1, 4'd0, 1, 1, "R6 carry-zero");
        op(16'h7FFF, 16'h0001, 1, 1, 4'd0, 1, 1, "R6 overflow");
        // R7 borrow and overflow
        op(16'h0000, 16'h0001, 1, 1, 4'd1, 1, 1, "R7 borrow");
        op(16'h8000, 16'h0001, 1, 1, 4'd1, 1, 1, "R7 overflow");
        // R4 compare equal: flags set, result held
        op(16'h1234, 16'h1234, 1, 1, 4'd10, 1, 1, "R4 compare-equal");
        op(16'h0001, 16'h0002, 1, 1, 4'd10, 1, 1, "R4 compare-less");
        // R8 shifts versus rotates of 0x8001
        op(16'h8001, 16'h0000, 1, 1, 4'd6, 1, 1, "R8 shl");
        op(16'h8001, 16'h0000, 1, 1, 4'd7, 1, 1, "R8 shr");
        op(16'h8001, 16'h0000, 1, 1, 4'd8, 1, 1, "R8 rol");
        op(16'h8001, 16'h0000, 1, 1, 4'd9, 1, 1, "R8 ror");
        // R5 / R9 logic
        op(16'hF0F0, 16'h0FF0, 1, 1, 4'd2, 1, 1, "R5 and");
        op(16'hFFFF, 16'h0000, 1, 1, 4'd5, 1, 1, "R9 not-zero");
        // R1: B reloaded, A held
        op(16'hAAAA, 16'h0003, 0, 1, 4'd0, 1, 1, "R1 hold-a");
        // R2: A reloaded, B held
        op(16'h0005, 16'h5555, 1, 0, 4'd3, 1, 1, "R2 hold-b");
        // R10: no strobe, flags held; R3: no result enable, result held
        op(16'h0000, 16'h0000, 1, 1, 4'd1, 0, 0, "R10 no-go");
        op(16'h1111, 16'h2222, 1, 1, 4'd0, 1, 0, "R3 no-write");
        // R10: invalid code with both strobes
        op(16'h4321, 16'h1234, 1, 1, 4'd13, 1, 1, "R10 invalid");

        for (int i = 0; i < 400; i++) begin
            logic [3:0] f;
            f = 4'($urandom % 16);
            op(16'($urandom), 16'($urandom), bit'($urandom % 4 != 0),
               bit'($urandom % 4 != 0), f, bit'($urandom % 4 != 0),
               bit'($urandom % 3 != 0), {tag(f), " random"});
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule